// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is the drawing core of a 2D accelerator for a 16-bit-per-pixel frame (RGB565) kept in a synchronous pixel memory with one cycle of read latency. An upstream queue hands it 32-bit command words, one per cycle, over a valid/ready handshake. Each word carries an opcode in its top byte and an operand in the low bits. Parameter commands load the destination address, source address, width, height and fill colour. A start command then launches either a solid fill of the destination rectangle or a copy of the source rectangle onto it.

The engine walks the rectangle in raster order from its top-left pixel. After each row it moves the row start on by the line pitch in bytes, which comes in on a separate input and is captured when an operation starts. While it works, `busy` is high and the command input is held off. When the last pixel has been written, `busy` drops and `done` pulses for one cycle.

Top module: `rect_blit_engine`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `done` are 0, `cmd_ready` is 1, and neither `mem_we` nor `mem_re` is asserted.
- R2: Command bits 31:24 are the opcode. Opcode 0x0C loads the destination byte address and 0x0D loads the source byte address, each from bits 23:0 with bit 0 forced to 0. Opcode 0x0E loads the width and 0x0F loads the height, each from bits 9:0. Opcode 0x0B loads the colour from bits 15:0. Higher operand bits are ignored, and every memory access uses an even byte address.
- R3: The width and height fields hold the pixel count minus one, so an operation touches exactly (width+1)*(height+1) pixels.
- R4: Opcode 0x23 writes the loaded colour to every pixel of the destination rectangle. Pixel c of row r is at byte address dst + r*pitch + 2*c. No other location is written.
- R5: Opcode 0x21 copies the source rectangle onto the destination rectangle in raster order. Each source pixel is read before its matching destination pixel is written, so overlapping regions behave like a sequential forward copy.
- R6: `busy` is high from the cycle after a start command is accepted until the last pixel write. `cmd_ready` is low whenever `busy` is high. `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again.
- R7: Opcodes that are not implemented, including 0x22, are accepted and have no effect. They cause no memory access, do not raise `busy`, and leave every parameter register unchanged.
- R8: Parameter registers keep their values across operations, so a start command without reloads repeats the previous geometry.
- R9: A fill writes one pixel per cycle, so `busy` lasts N cycles for N pixels. A copy takes two cycles per pixel, so `busy` lasts 2N cycles.
- R10: The line pitch is captured when a start command is accepted. Changing `line_pitch` while `busy` is high does not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine can take a command (low while busy) |
| cmd_data | input | 32 | Command word: opcode in 31:24, operand below |
| line_pitch | input | PITCH_W | Byte distance between successive rows |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final pixel write |
| mem_addr | output | ADDR_W | Pixel memory byte address |
| mem_re | output | 1 | Pixel memory read strobe (data returns next cycle) |
| mem_we | output | 1 | Pixel memory write strobe |
| mem_wdata | output | 16 | Pixel write data |
| mem_rdata | input | 16 | Pixel read data, registered by the memory |

## Verification
The hardest situations to reach are the ones that depend on state left over from earlier commands. These are a start command issued with no fresh parameters, ignored opcodes arriving between operations, and a pitch change landing in the middle of a walk. The bench sets them up on purpose. It sends a burst of unimplemented opcodes carrying operands that would visibly change the geometry if they were decoded, then starts a fill that relies only on retained registers. In a separate run it changes the pitch input on the first busy cycle. It also sweeps every width and height from one to three pixels for both operations, plus a copy whose destination overlaps its own source one pixel ahead. Each result is compared word by word against a reference frame that the bench updates by its own arithmetic.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int ADDR_W = 24;
    localparam int CNT_W  = 10;
    localparam int PIX_W  = 16;

    localparam logic [7:0] OPC_COLOUR  = 8'h0B;
    localparam logic [7:0] OPC_DST     = 8'h0C;
    localparam logic [7:0] OPC_SRC     = 8'h0D;
    localparam logic [7:0] OPC_WIDTH   = 8'h0E;
    localparam logic [7:0] OPC_HEIGHT  = 8'h0F;
    localparam logic [7:0] OPC_COPY_GO = 8'h21;
    localparam logic [7:0] OPC_FILL_GO = 8'h23;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE
    } walk_state_t;

    typedef enum logic [1:0] {
        KICK_NONE,
        KICK_FILL,
        KICK_COPY
    } kick_t;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [CNT_W-1:0]  wm1;
        logic [CNT_W-1:0]  hm1;
        logic [PIX_W-1:0]  colour;
    } blit_params_t;

    function automatic logic [ADDR_W-1:0] even_addr(input logic [31:0] word);
        logic [ADDR_W-1:0] a;
        a = word[ADDR_W-1:0];
        a[0] = 1'b0;
        return a;
    endfunction

endpackage

// File: rtl/blit_cmd_regs.sv
module blit_cmd_regs
    import blit_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [31:0]  cmd_data,
    input  logic         busy,
    output logic         cmd_ready,
    output blit_params_t params,
    output kick_t        kick
);

    logic       accept;
    logic [7:0] opcode;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign opcode    = cmd_data[31:24];

    always_ff @(posedge clk) begin
        if (rst) begin
            params <= '0;
        end else if (accept) begin
            case (opcode)
                OPC_DST:    params.dst    <= even_addr(cmd_data);
                OPC_SRC:    params.src    <= even_addr(cmd_data);
                OPC_WIDTH:  params.wm1    <= cmd_data[CNT_W-1:0];
                OPC_HEIGHT: params.hm1    <= cmd_data[CNT_W-1:0];
                OPC_COLOUR: params.colour <= cmd_data[PIX_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        kick = KICK_NONE;
        if (accept) begin
            if (opcode == OPC_FILL_GO)      kick = KICK_FILL;
            else if (opcode == OPC_COPY_GO) kick = KICK_COPY;
        end
    end

    // R6
    kick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (kick != KICK_NONE) |-> !busy);

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  kick_t              kick,
    input  blit_params_t       params,
    input  logic [PITCH_W-1:0] line_pitch,
    input  logic [PIX_W-1:0]   mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [PIX_W-1:0]   mem_wdata
);

    localparam int PIX_BYTES = PIX_W / 8;

    walk_state_t       state;
    logic [ADDR_W-1:0] row_dst, row_src, cur_dst, cur_src;
    logic [ADDR_W-1:0] pitch_q, next_row_dst, next_row_src;
    logic [CNT_W-1:0]  col, row;
    logic              last_col, last_row, step;

    assign last_col     = (col == params.wm1);
    assign last_row     = (row == params.hm1);
    assign step         = mem_we;
    assign next_row_dst = row_dst + pitch_q;
    assign next_row_src = row_src + pitch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            row_dst <= '0;
            row_src <= '0;
            cur_dst <= '0;
            cur_src <= '0;
            pitch_q <= '0;
            col     <= '0;
            row     <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (kick != KICK_NONE) begin
                    row_dst <= params.dst;
                    cur_dst <= params.dst;
                    row_src <= params.src;
                    cur_src <= params.src;
                    pitch_q <= ADDR_W'(line_pitch);
                    col     <= '0;
                    row     <= '0;
                    state   <= (kick == KICK_FILL) ? ST_FILL : ST_READ;
                end
            end else if (state == ST_READ) begin
                state <= ST_WRITE;
            end else if (step) begin
                if (last_col && last_row) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    if (last_col) begin
                        col     <= '0;
                        row     <= row + 1'b1;
                        row_dst <= next_row_dst;
                        row_src <= next_row_src;
                        cur_dst <= next_row_dst;
                        cur_src <= next_row_src;
                    end else begin
                        col     <= col + 1'b1;
                        cur_dst <= cur_dst + ADDR_W'(PIX_BYTES);
                        cur_src <= cur_src + ADDR_W'(PIX_BYTES);
                    end
                    if (state == ST_WRITE) state <= ST_READ;
                end
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_re    = (state == ST_READ);
        mem_we    = (state == ST_FILL) || (state == ST_WRITE);
        mem_addr  = (state == ST_READ) ? cur_src : cur_dst;
        mem_wdata = (state == ST_FILL) ? params.colour : mem_rdata;
    end

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R2
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> !mem_addr[0]);
    // R5
    copy_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == ST_WRITE) |-> $past(mem_re));

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import blit_pkg::*;
#(
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [31:0]        cmd_data,
    input  logic [PITCH_W-1:0] line_pitch,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [PIX_W-1:0]   mem_wdata,
    input  logic [PIX_W-1:0]   mem_rdata
);

    blit_params_t params;
    kick_t        kick;

    blit_cmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .cmd_ready (cmd_ready),
        .params    (params),
        .kick      (kick)
    );

    blit_walker #(.PITCH_W(PITCH_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .params     (params),
        .line_pitch (line_pitch),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata)
    );

    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

endmodule

// File: tb/test_rect_blit_engine.sv
`timescale 1ns/1ps
module test_rect_blit_engine;

    localparam int WORDS = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_data = '0;
    logic [15:0] line_pitch = 16'd64;
    logic        busy, done, mem_re, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem     [0:WORDS-1];
    logic [15:0] ref_mem [0:WORDS-1];
    logic        tb_we = 1'b0;
    logic [10:0] tb_idx = '0;
    logic [15:0] tb_d = '0;
    int          wr_count = 0;
    int          tests = 0;
    int          fails = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    rect_blit_engine i_rect_blit_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .line_pitch(line_pitch), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:1]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end else if (tb_we) begin
            mem[tb_idx] <= tb_d;
        end
        if (mem_re) mem_rdata <= mem[mem_addr[11:1]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    function automatic int ridx(input int a);
        return (a >> 1) & (WORDS - 1);
    endfunction

    task automatic ref_fill(input int dst, input int w, input int h, input int col, input int pitch);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                ref_mem[ridx((dst & ~1) + r * pitch + 2 * c)] = col[15:0];
    endtask

    task automatic ref_copy(input int dst, input int src, input int w, input int h, input int pitch);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                ref_mem[ridx((dst & ~1) + r * pitch + 2 * c)] =
                    ref_mem[ridx((src & ~1) + r * pitch + 2 * c)];
    endtask

    task automatic check_mem(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < WORDS; i++)
            if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " mem word"}, int'(mem[bad]), int'(ref_mem[bad]));
    endtask

    // waits for the running operation; pitch_switch >= 0 changes the pitch on the first busy cycle
    task automatic run_op(input int exp_cycles, input string req, input int pitch_switch);
        int cnt;
        bit rdy_bad;
        cnt = 0;
        rdy_bad = 0;
        @(negedge clk);
        while (busy && cnt < 5000) begin
            if (cmd_ready) rdy_bad = 1;
            if (cnt == 0 && pitch_switch >= 0) line_pitch = pitch_switch[15:0];
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_cycles, {req, " R9 busy cycles"}, cnt, exp_cycles);
        check(!rdy_bad, {req, " R6 ready low while busy"}, rdy_bad, 0);
        check(done == 1'b1, {req, " R6 done after last write"}, done, 1);
        @(negedge clk);
        check(done == 1'b0 && !busy, {req, " R6 done one cycle"}, done, 0);
    endtask

    task automatic do_fill(input int dst, input int w, input int h, input int col, input string req);
        send({8'h0C, 24'(dst)});
        send({8'h0E, 24'(w - 1)});
        send({8'h0F, 24'(h - 1)});
        send({8'h0B, 8'h00, col[15:0]});
        send(32'h2300_0000);
        ref_fill(dst, w, h, col, int'(line_pitch));
        run_op(w * h, req, -1);
        check_mem(req);
    endtask

    task automatic do_copy(input int dst, input int src, input int w, input int h, input string req);
        send({8'h0C, 24'(dst)});
        send({8'h0E, 24'(w - 1)});
        send({8'h0F, 24'(h - 1)});
        send({8'h0D, 24'(src)});
        send(32'h2100_0000);
        ref_copy(dst, src, w, h, int'(line_pitch));
        run_op(2 * w * h, req, -1);
        check_mem(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int wc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && cmd_ready && !mem_we && !mem_re, "R1 reset outputs",
              {busy, done, cmd_ready, mem_we, mem_re}, 5'b00100);
        for (int i = 0; i < WORDS; i++) begin
            tb_we  = 1'b1;
            tb_idx = 11'(i);
            tb_d   = 16'(i) ^ 16'hA5A5;
            ref_mem[i] = 16'(i) ^ 16'hA5A5;
            @(negedge clk);
        end
        tb_we = 1'b0;
        rst   = 1'b0;
        @(negedge clk);
        check(cmd_ready && !busy, "R1 ready after reset", cmd_ready, 1);

        // R3 R4 R9 fill sweep
        for (int w = 1; w <= 3; w++)
            for (int h = 1; h <= 3; h++)
                do_fill(32'h100 + (h * 3 + w) * 32'h180, w, h, 32'h1000 + w * 16 + h, "R4 fill");

        // R5 R9 copy sweep
        for (int w = 1; w <= 3; w++)
            for (int h = 1; h <= 3; h++)
                do_copy(32'h800 + (h * 3 + w) * 32'h60, 32'h40 + w * 4, w, h, "R5 copy");

        // R5 overlapping forward copy, one pixel ahead
        do_copy(32'h402, 32'h400, 4, 1, "R5 overlap copy");

        // R2 odd address forced even, width operand with high garbage masked to 10 bits
        send(32'h0C00_0301);
        send(32'h0EFF_FC01);
        send(32'h0F00_0000);
        send(32'h0B00_7E57);
        send(32'h2300_0000);
        ref_fill(32'h300, 2, 1, 32'h7E57, 64);
        run_op(2, "R2 masked operands", -1);
        check_mem("R2 masked operands");

        // R7 unimplemented opcodes ignored
        wc = wr_count;
        send(32'h2200_0000);
        send(32'h0500_0123);
        send(32'h3F00_FFFF);
        repeat (4) begin
            @(negedge clk);
            check(!busy, "R7 no busy on ignored opcode", busy, 0);
        end
        check(wr_count == wc, "R7 no writes on ignored opcode", wr_count, wc);
        check_mem("R7 memory untouched");

        // R8 retained parameters: new colour only, then start
        send(32'h0B00_BEEF);
        send(32'h2300_0000);
        ref_fill(32'h300, 2, 1, 32'hBEEF, 64);
        run_op(2, "R8 retained params", -1);
        check_mem("R8 retained params");

        // R10 pitch changed mid-operation
        send(32'h0C00_0E00);
        send(32'h0E00_0001);
        send(32'h0F00_0002);
        send(32'h0B00_C0DE);
        send(32'h2300_0000);
        ref_fill(32'hE00, 2, 3, 32'hC0DE, 64);
        run_op(6, "R10 pitch capture", 128);
        check_mem("R10 pitch capture");
        line_pitch = 16'd64;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule